// File: doc/BRIEF.md
# Chained Word DMA Channel

This block is one DMA channel for a simple peripheral bus. Software programs it through a small slave register window. The window holds one control/status word, a current address and a byte count. A second "next" address/count pair lies behind the same two offsets. Once enabled and loaded, the channel requests one 32-bit word transfer at a time toward memory. Each accepted word moves the address up by four and, when counting is on, takes four bytes off the count.

When the count runs out, the terminal-count flag is raised. If chaining is armed and a next pair has been written, that pair becomes the current one in the same cycle, and the request continues with no idle cycle. Without a loaded next pair, the channel switches itself off. A single interrupt line reports terminal count, which can be masked, and transfer errors. A soft-reset bit holds the channel quiet until software clears it.

Top module: `dma_chan_ctl`

## Requirements
- R1: After hardware reset the control/status word reads 0xC000_0000: device ID 0xC in bits 31:28 and every other bit 0. Address and count read 0, `irq` is 0 and `xfer_req` is 0.
- R2: Offset 0 is control/status, offset 4 is address and offset 8 is byte count. While bit 24 (chain enable) is 1, writes to offsets 4 and 8 reach the next pair, otherwise the current pair. Reads of 4 and 8 always return the current pair. Bit 26 sets when the current address is written and bit 27 sets when the next address is written.
- R3: `xfer_req` is 1 exactly when bit 9 (enable) is 1, bit 7 (soft reset) is 0, bit 26 is 1, and either bit 13 (count enable) is 0 or the count is nonzero. `xfer_addr` shows the current address and `xfer_dir` shows bit 8 (1 = device to memory).
- R4: A word is accepted when `xfer_req` and `xfer_ack` are both 1. Each accepted word adds 4 to the address. With bit 13 set it also subtracts 4 from the count, flooring at 0.
- R5: An accepted word that brings the count to 0 with bit 13 set raises bit 14 (terminal count). Writing 1 to bit 14 clears it, and writing 0 leaves it alone.
- R6: On terminal count with bits 24 and 27 both set, the next address and count are copied into the current pair in that same cycle. Bit 27 then clears, bit 26 stays set, and `xfer_req` stays high.
- R7: On terminal count without a loaded next pair, bit 9 clears and `xfer_req` drops.
- R8: With bit 13 clear the count is never changed by transfers, terminal count never rises and no reload happens.
- R9: `irq` = bit 4 AND (bit 1 OR (bit 14 AND NOT bit 23)). Bit 0 reads the bracketed cause, without bit 4.
- R10: An accepted word with `xfer_err` high sets bit 1 (error pending). This also clears bit 9 unless bit 22 is set. Writing 1 to bit 1 clears it.
- R11: While bit 7 is 1, no request is made and bits 1, 14, 26 and 27 are held at 0. Bit 7 keeps its value until software writes it.
- R12: `xfer_burst` decodes bits 19:18 as 00→4, 01→8, 10→1, 11→16 words.
- R13: Bit 10 reads 1 while a request is pending. Bit 25 reads bit 9 AND NOT bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| xfer_req | output | 1 | Word transfer requested |
| xfer_ack | input | 1 | Memory side accepts the word this cycle |
| xfer_err | input | 1 | The accepted word ended in error |
| xfer_addr | output | 32 | Address of the requested word |
| xfer_dir | output | 1 | 1 = device to memory, 0 = memory to device |
| xfer_burst | output | 5 | Configured burst length in words |
| irq | output | 1 | Interrupt request |

## Verification
Acknowledge is driven as solid, alternating and pseudo-random streams. Solid acknowledge shows that the chained reload leaves no gap. The broken patterns show that address and count move only on accepted words. A chain of two segments is run to exhaustion. This separates the reload on the first terminal count from the self-stop on the second. An odd byte count checks that the count floors at zero. Error pulses are given with and without the no-stop bit, and the interrupt is read with the terminal-count mask both clear and set.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int unsigned WORD_BYTES = 4;

  localparam logic [3:0] OFF_CSR  = 4'h0;
  localparam logic [3:0] OFF_ADDR = 4'h4;
  localparam logic [3:0] OFF_CNT  = 4'h8;

  localparam int B_IPEND  = 0;
  localparam int B_EPEND  = 1;
  localparam int B_IEN    = 4;
  localparam int B_SRST   = 7;
  localparam int B_DIR    = 8;
  localparam int B_EN     = 9;
  localparam int B_CYC    = 10;
  localparam int B_CEN    = 13;
  localparam int B_TC     = 14;
  localparam int B_BLO    = 18;
  localparam int B_BHI    = 19;
  localparam int B_DERR   = 22;
  localparam int B_TCIDIS = 23;
  localparam int B_NXEN   = 24;
  localparam int B_ON     = 25;
  localparam int B_AL     = 26;
  localparam int B_NAL    = 27;

  typedef struct packed {
    logic       nx_en;
    logic       tc_nointr;
    logic       err_nostop;
    logic [1:0] burst;
    logic       tc_clr;
    logic       cnt_en;
    logic       dma_en;
    logic       dir;
    logic       srst;
    logic       err_clr;
    logic       int_en;
  } csr_fields_t;

  function automatic logic [4:0] burst_words(input logic [1:0] code);
    case (code)
      2'b00:   return 5'd4;
      2'b01:   return 5'd8;
      2'b10:   return 5'd1;
      default: return 5'd16;
    endcase
  endfunction

  function automatic logic [31:0] addr_step(input logic [31:0] a);
    return a + 32'(WORD_BYTES);
  endfunction

  function automatic logic [31:0] count_step(input logic [31:0] c);
    return (c >= 32'(WORD_BYTES)) ? c - 32'(WORD_BYTES) : 32'd0;
  endfunction

endpackage

// File: rtl/dma_chan_ptr.sv
module dma_chan_ptr
  import dma_chan_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             wr_addr,
  input  logic             wr_cnt,
  input  logic             next_en,
  input  logic             cnt_en,
  input  logic [31:0]      wdata,
  input  logic             word_done,
  output logic [31:0]      cur_addr,
  output logic [CNT_W-1:0] cur_cnt,
  output logic             a_loaded,
  output logic             na_loaded,
  output logic             cnt_zero,
  output logic             tc_hit,
  output logic             reload_go
);

  logic [31:0]      next_addr;
  logic [CNT_W-1:0] next_cnt;
  logic [CNT_W-1:0] cnt_after;
  logic             wr_cur_addr, wr_nxt_addr, wr_cur_cnt, wr_nxt_cnt;

  assign wr_cur_addr = wr_addr & ~next_en;
  assign wr_nxt_addr = wr_addr &  next_en;
  assign wr_cur_cnt  = wr_cnt  & ~next_en;
  assign wr_nxt_cnt  = wr_cnt  &  next_en;

  assign cnt_after = CNT_W'(count_step(32'(cur_cnt)));
  assign cnt_zero  = (cur_cnt == '0);
  assign tc_hit    = word_done & cnt_en & (cnt_after == '0);
  assign reload_go = tc_hit & next_en & na_loaded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      cur_cnt   <= '0;
      next_addr <= '0;
      next_cnt  <= '0;
    end else begin
      if (wr_nxt_addr) next_addr <= wdata;
      if (wr_nxt_cnt)  next_cnt  <= wdata[CNT_W-1:0];
      if (wr_cur_addr)    cur_addr <= wdata;
      else if (word_done) cur_addr <= reload_go ? next_addr : addr_step(cur_addr);
      if (wr_cur_cnt)               cur_cnt <= wdata[CNT_W-1:0];
      else if (word_done && cnt_en) cur_cnt <= reload_go ? next_cnt : cnt_after;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_loaded  <= 1'b0;
      na_loaded <= 1'b0;
    end else if (srst) begin
      a_loaded  <= 1'b0;
      na_loaded <= 1'b0;
    end else begin
      if (wr_cur_addr) a_loaded <= 1'b1;
      if (wr_nxt_addr)    na_loaded <= 1'b1;
      else if (reload_go) na_loaded <= 1'b0;
    end
  end

  AST_RELOAD_NA_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    reload_go && !wr_nxt_addr |=> !na_loaded); // R6
  AST_RELOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    reload_go && !wr_cur_addr && !wr_nxt_addr |=> cur_addr == $past(next_addr)); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && !reload_go && !wr_cur_addr |=> cur_addr == $past(cur_addr) + 32'd4); // R4
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en && !wr_cur_cnt |=> $stable(cur_cnt)); // R8

endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_chan_pkg::*;
#(
  parameter logic [3:0] DEV_ID = 4'hC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_wr,
  input  csr_fields_t wf,
  input  logic        tc_hit,
  input  logic        err_hit,
  input  logic        halt_go,
  input  logic        cyc_pend,
  input  logic        a_loaded,
  input  logic        na_loaded,
  output logic        int_en,
  output logic        srst,
  output logic        dir,
  output logic        dma_en,
  output logic        cnt_en,
  output logic        err_nostop,
  output logic        tc_nointr,
  output logic        next_en,
  output logic [1:0]  burst,
  output logic        tc_flag,
  output logic        err_flag,
  output logic        intr_cause,
  output logic [31:0] csr_value
);

  logic err_stop;
  assign err_stop = err_hit & ~err_nostop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en     <= 1'b0;
      srst       <= 1'b0;
      dir        <= 1'b0;
      dma_en     <= 1'b0;
      cnt_en     <= 1'b0;
      err_nostop <= 1'b0;
      tc_nointr  <= 1'b0;
      next_en    <= 1'b0;
      burst      <= 2'b00;
    end else begin
      if (csr_wr) begin
        int_en     <= wf.int_en;
        srst       <= wf.srst;
        dir        <= wf.dir;
        dma_en     <= wf.dma_en;
        cnt_en     <= wf.cnt_en;
        err_nostop <= wf.err_nostop;
        tc_nointr  <= wf.tc_nointr;
        next_en    <= wf.nx_en;
        burst      <= wf.burst;
      end
      if (halt_go || err_stop) dma_en <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_flag  <= 1'b0;
      err_flag <= 1'b0;
    end else if (srst) begin
      tc_flag  <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      if (tc_hit)                   tc_flag <= 1'b1;
      else if (csr_wr && wf.tc_clr) tc_flag <= 1'b0;
      if (err_hit)                   err_flag <= 1'b1;
      else if (csr_wr && wf.err_clr) err_flag <= 1'b0;
    end
  end

  assign intr_cause = err_flag | (tc_flag & ~tc_nointr);

  always_comb begin
    csr_value             = '0;
    csr_value[31:28]      = DEV_ID;
    csr_value[B_NAL]      = na_loaded;
    csr_value[B_AL]       = a_loaded;
    csr_value[B_ON]       = dma_en & ~srst;
    csr_value[B_NXEN]     = next_en;
    csr_value[B_TCIDIS]   = tc_nointr;
    csr_value[B_DERR]     = err_nostop;
    csr_value[B_BHI:B_BLO] = burst;
    csr_value[B_TC]       = tc_flag;
    csr_value[B_CEN]      = cnt_en;
    csr_value[B_CYC]      = cyc_pend;
    csr_value[B_EN]       = dma_en;
    csr_value[B_DIR]      = dir;
    csr_value[B_SRST]     = srst;
    csr_value[B_IEN]      = int_en;
    csr_value[B_EPEND]    = err_flag;
    csr_value[B_IPEND]    = intr_cause;
  end

  AST_TC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tc_hit && !srst |=> tc_flag); // R5
  AST_TC_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr && wf.tc_clr && !tc_hit |=> !tc_flag); // R5
  AST_HALT_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    halt_go |=> !dma_en); // R7
  AST_ERR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    err_hit && !err_nostop |=> !dma_en); // R10
  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !tc_flag && !err_flag); // R11

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_pkg::*;
#(
  parameter int         CNT_W  = 24,
  parameter logic [3:0] DEV_ID = 4'hC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        xfer_req,
  input  logic        xfer_ack,
  input  logic        xfer_err,
  output logic [31:0] xfer_addr,
  output logic        xfer_dir,
  output logic [4:0]  xfer_burst,
  output logic        irq
);

  csr_fields_t      wf;
  logic             csr_wr, wr_addr, wr_cnt;
  logic             word_done, err_hit, tc_hit, reload_go, halt_go;
  logic             int_en, srst, dma_en, cnt_en, err_nostop, tc_nointr, next_en;
  logic [1:0]       burst;
  logic             tc_flag, err_flag, intr_cause;
  logic [31:0]      csr_value, cur_addr;
  logic [CNT_W-1:0] cur_cnt;
  logic             a_loaded, na_loaded, cnt_zero;
  logic             unused_wbits;

  assign csr_wr  = reg_wr & (reg_addr == OFF_CSR);
  assign wr_addr = reg_wr & (reg_addr == OFF_ADDR);
  assign wr_cnt  = reg_wr & (reg_addr == OFF_CNT);

  assign wf.nx_en      = reg_wdata[B_NXEN];
  assign wf.tc_nointr  = reg_wdata[B_TCIDIS];
  assign wf.err_nostop = reg_wdata[B_DERR];
  assign wf.burst      = reg_wdata[B_BHI:B_BLO];
  assign wf.tc_clr     = reg_wdata[B_TC];
  assign wf.cnt_en     = reg_wdata[B_CEN];
  assign wf.dma_en     = reg_wdata[B_EN];
  assign wf.dir        = reg_wdata[B_DIR];
  assign wf.srst       = reg_wdata[B_SRST];
  assign wf.err_clr    = reg_wdata[B_EPEND];
  assign wf.int_en     = reg_wdata[B_IEN];

  assign xfer_req  = dma_en & ~srst & a_loaded & (~cnt_en | ~cnt_zero);
  assign word_done = xfer_req & xfer_ack;
  assign err_hit   = word_done & xfer_err;
  assign halt_go   = tc_hit & ~reload_go;

  dma_chan_ptr #(.CNT_W(CNT_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .srst      (srst),
    .wr_addr   (wr_addr),
    .wr_cnt    (wr_cnt),
    .next_en   (next_en),
    .cnt_en    (cnt_en),
    .wdata     (reg_wdata),
    .word_done (word_done),
    .cur_addr  (cur_addr),
    .cur_cnt   (cur_cnt),
    .a_loaded  (a_loaded),
    .na_loaded (na_loaded),
    .cnt_zero  (cnt_zero),
    .tc_hit    (tc_hit),
    .reload_go (reload_go)
  );

  dma_chan_csr #(.DEV_ID(DEV_ID)) u_csr (
    .clk        (clk),
    .rst_n      (rst_n),
    .csr_wr     (csr_wr),
    .wf         (wf),
    .tc_hit     (tc_hit),
    .err_hit    (err_hit),
    .halt_go    (halt_go),
    .cyc_pend   (xfer_req),
    .a_loaded   (a_loaded),
    .na_loaded  (na_loaded),
    .int_en     (int_en),
    .srst       (srst),
    .dir        (xfer_dir),
    .dma_en     (dma_en),
    .cnt_en     (cnt_en),
    .err_nostop (err_nostop),
    .tc_nointr  (tc_nointr),
    .next_en    (next_en),
    .burst      (burst),
    .tc_flag    (tc_flag),
    .err_flag   (err_flag),
    .intr_cause (intr_cause),
    .csr_value  (csr_value)
  );

  assign irq        = int_en & intr_cause;
  assign xfer_addr  = cur_addr;
  assign xfer_burst = burst_words(burst);

  assign unused_wbits = ^{reg_wdata[31:28], reg_wdata[21:20], reg_wdata[17:15],
                          reg_wdata[12:11], reg_wdata[6:5], reg_wdata[3:2]};

  always_comb begin
    case (reg_addr)
      OFF_CSR:  reg_rdata = csr_value;
      OFF_ADDR: reg_rdata = cur_addr;
      OFF_CNT:  reg_rdata = 32'(cur_cnt);
      default:  reg_rdata = '0;
    endcase
  end

  AST_TC_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    tc_hit && int_en && !tc_nointr && !srst && !reg_wr |=> irq); // R9
  AST_NO_REQ_AFTER_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    halt_go && !reg_wr |=> !xfer_req); // R7
  AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(srst) && srst |-> !xfer_req && !a_loaded); // R11

endmodule

// File: tb/test_dma_chan_ctl.sv
module test_dma_chan_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 24;
  localparam logic [31:0] C_IEN = 32'h1 << 4, C_SRST = 32'h1 << 7, C_DIR = 32'h1 << 8,
    C_EN = 32'h1 << 9, C_CYC = 32'h1 << 10, C_CEN = 32'h1 << 13, C_TC = 32'h1 << 14,
    C_DERR = 32'h1 << 22, C_TCD = 32'h1 << 23, C_NX = 32'h1 << 24, C_ON = 32'h1 << 25,
    C_AL = 32'h1 << 26, C_NAL = 32'h1 << 27, C_ERR = 32'h1 << 1;

  logic clk = 0, rst_n = 0, reg_wr = 0, xfer_ack = 0, xfer_err = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, xfer_addr;
  logic xfer_req, xfer_dir, irq;
  logic [4:0] xfer_burst;
  int checks = 0, failures = 0, ack_mode = 0;
  bit finished = 0;
  logic [7:0] lfsr = 8'h5A;

  dma_chan_ctl #(.CNT_W(CW)) i_dma_chan_ctl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  bit m_ie, m_srst, m_dir, m_en, m_ce, m_derr, m_tcd, m_nx, m_tc, m_err, m_al, m_nal;
  bit [1:0] m_burst;
  logic [31:0] m_addr, m_naddr;
  logic [CW-1:0] m_cnt, m_ncnt;

  function automatic bit m_req();
    return m_en && !m_srst && m_al && (!m_ce || m_cnt != 0);
  endfunction
  function automatic bit m_irq();
    return m_ie && (m_err || (m_tc && !m_tcd));
  endfunction
  function automatic logic [31:0] m_csr();
    logic [31:0] c = 32'hC000_0000;
    c[27] = m_nal; c[26] = m_al; c[25] = m_en && !m_srst; c[24] = m_nx; c[23] = m_tcd;
    c[22] = m_derr; c[19:18] = m_burst; c[14] = m_tc; c[13] = m_ce; c[10] = m_req();
    c[9] = m_en; c[8] = m_dir; c[7] = m_srst; c[4] = m_ie; c[1] = m_err;
    c[0] = m_err || (m_tc && !m_tcd);
    return c;
  endfunction
  function automatic logic [4:0] m_bw();
    int lens[4] = '{4, 8, 1, 16};
    return 5'(lens[m_burst]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_ie, m_srst, m_dir, m_en, m_ce, m_derr, m_tcd, m_nx, m_tc, m_err, m_al, m_nal} = '0;
      m_burst = 0; m_addr = 0; m_naddr = 0; m_cnt = 0; m_ncnt = 0;
    end else begin
      bit done, tch, rl, errh, s0, nx0, derr0;
      int after;
      logic [31:0] naddr0;
      logic [CW-1:0] ncnt0;
      done = m_req() && xfer_ack;
      after = (m_cnt >= 4) ? int'(m_cnt) - 4 : 0;
      tch = done && m_ce && after == 0;
      rl = tch && m_nx && m_nal;
      errh = done && xfer_err;
      s0 = m_srst; nx0 = m_nx; derr0 = m_derr; naddr0 = m_naddr; ncnt0 = m_ncnt;
      if (reg_wr && reg_addr == 0) begin
        m_ie = reg_wdata[4]; m_srst = reg_wdata[7]; m_dir = reg_wdata[8]; m_en = reg_wdata[9];
        m_ce = reg_wdata[13]; m_burst = reg_wdata[19:18]; m_derr = reg_wdata[22];
        m_tcd = reg_wdata[23]; m_nx = reg_wdata[24];
      end
      if ((tch && !rl) || (errh && !derr0)) m_en = 0;
      if (s0) begin m_tc = 0; m_err = 0; end
      else begin
        if (tch) m_tc = 1; else if (reg_wr && reg_addr == 0 && reg_wdata[14]) m_tc = 0;
        if (errh) m_err = 1; else if (reg_wr && reg_addr == 0 && reg_wdata[1]) m_err = 0;
      end
      if (reg_wr && reg_addr == 4 && nx0) m_naddr = reg_wdata;
      if (reg_wr && reg_addr == 8 && nx0) m_ncnt = reg_wdata[CW-1:0];
      if (reg_wr && reg_addr == 4 && !nx0) m_addr = reg_wdata;
      else if (done) m_addr = rl ? naddr0 : m_addr + 4;
      if (reg_wr && reg_addr == 8 && !nx0) m_cnt = reg_wdata[CW-1:0];
      else if (done && m_ce) m_cnt = rl ? ncnt0 : CW'(after);
      if (s0) begin m_al = 0; m_nal = 0; end
      else begin
        if (reg_wr && reg_addr == 4 && !nx0) m_al = 1;
        if (reg_wr && reg_addr == 4 && nx0) m_nal = 1; else if (rl) m_nal = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [31:0] er;
      chk(xfer_req == m_req(), "R3 R6 R7 xfer_req", 32'(xfer_req), 32'(m_req()));
      chk(xfer_addr == m_addr, "R4 xfer_addr", xfer_addr, m_addr);
      chk(xfer_dir == m_dir, "R3 xfer_dir", 32'(xfer_dir), 32'(m_dir));
      chk(irq == m_irq(), "R9 irq", 32'(irq), 32'(m_irq()));
      chk(xfer_burst == m_bw(), "R12 xfer_burst", 32'(xfer_burst), 32'(m_bw()));
      case (reg_addr)
        4'h0: er = m_csr();
        4'h4: er = m_addr;
        4'h8: er = 32'(m_cnt);
        default: er = 0;
      endcase
      chk(reg_rdata == er, "R2 reg_rdata", reg_rdata, er);
    end
  end

  always @(negedge clk) begin
    #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (ack_mode)
      1: xfer_ack = 1;
      2: xfer_ack = ~xfer_ack;
      3: xfer_ack = lfsr[0];
      default: xfer_ack = 0;
    endcase
  end

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); #2; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #2; reg_wr = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); #2; end
  endtask
  task automatic rd_chk(input logic [3:0] a, input logic [31:0] mask, input logic [31:0] exp, input string tag);
    @(negedge clk); #2; reg_addr = a; #1;
    chk((reg_rdata & mask) == exp, tag, reg_rdata & mask, exp);
  endtask
  task automatic pulse_err();
    @(negedge clk); #2; xfer_err = 1;
    @(negedge clk); #2; xfer_err = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      finished = 1; failures++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int bw[4] = '{4, 8, 1, 16};
    idle(3);
    rst_n = 1;
    rd_chk(4'h0, 32'hFFFF_FFFF, 32'hC000_0000, "R1 csr reset");
    rd_chk(4'h8, 32'hFFFF_FFFF, 32'h0, "R1 count reset");
    chk(irq == 0 && xfer_req == 0, "R1 outputs reset", {30'b0, irq, xfer_req}, 0);

    // soft reset holds the channel
    wr_reg(4'h0, C_SRST);
    wr_reg(4'h4, 32'h0000_0100);
    idle(2);
    rd_chk(4'h0, C_SRST | C_AL, C_SRST, "R11 srst held, address not marked loaded");
    wr_reg(4'h0, 0);
    rd_chk(4'h0, C_SRST, 0, "R11 srst released by write");

    // program next pair then current pair
    wr_reg(4'h0, C_NX);
    wr_reg(4'h4, 32'h0000_2000);
    wr_reg(4'h8, 32'd8);
    wr_reg(4'h0, 0);
    wr_reg(4'h4, 32'h0000_1000);
    wr_reg(4'h8, 32'd16);
    rd_chk(4'h4, 32'hFFFF_FFFF, 32'h0000_1000, "R2 read returns current address");
    rd_chk(4'h0, C_AL | C_NAL, C_AL | C_NAL, "R2 loaded flags");
    ack_mode = 1;
    wr_reg(4'h0, C_NX | C_CEN | C_EN | C_IEN | C_DIR | (32'h1 << 18));
    rd_chk(4'h0, C_CYC | C_ON, C_CYC | C_ON, "R13 pending and on");
    idle(12);
    rd_chk(4'h4, 32'hFFFF_FFFF, 32'h0000_2008, "R6 chained address continued");
    rd_chk(4'h0, C_NAL | C_AL, C_AL, "R6 next flag cleared, current kept");
    rd_chk(4'h0, C_TC, C_TC, "R5 terminal count set");
    rd_chk(4'h0, C_EN, 0, "R7 enable dropped");
    chk(irq == 1, "R9 irq on terminal count", 32'(irq), 1);
    wr_reg(4'h0, C_TCD | C_IEN | C_CEN);
    idle(1);
    chk(irq == 0, "R9 irq masked by bit 23", 32'(irq), 0);
    wr_reg(4'h0, C_IEN);
    rd_chk(4'h0, C_TC, C_TC, "R5 writing 0 keeps terminal count");
    wr_reg(4'h0, C_TC | C_IEN);
    rd_chk(4'h0, C_TC, 0, "R5 write one clears");

    // counter disabled
    ack_mode = 2;
    wr_reg(4'h4, 32'h0000_3000);
    wr_reg(4'h8, 32'd40);
    wr_reg(4'h0, C_EN);
    idle(10);
    wr_reg(4'h0, 0);
    rd_chk(4'h8, 32'hFFFF_FFFF, 32'd40, "R8 count frozen");
    rd_chk(4'h0, C_TC, 0, "R8 no terminal count");

    // errors
    ack_mode = 1;
    wr_reg(4'h8, 32'd200);
    wr_reg(4'h0, C_EN | C_CEN | C_IEN);
    pulse_err();
    idle(2);
    rd_chk(4'h0, C_ERR | C_EN, C_ERR, "R10 error stops channel");
    chk(irq == 1, "R10 R9 irq on error", 32'(irq), 1);
    wr_reg(4'h0, C_ERR | C_DERR | C_EN | C_CEN);
    rd_chk(4'h0, C_ERR | C_EN, C_EN, "R10 error cleared, running");
    pulse_err();
    idle(2);
    rd_chk(4'h0, C_ERR | C_EN, C_ERR | C_EN, "R10 no-stop keeps running");
    wr_reg(4'h0, C_ERR);

    // burst decode
    for (int k = 0; k < 4; k++) begin
      wr_reg(4'h0, 32'(k) << 18);
      idle(1);
      chk(xfer_burst == 5'(bw[k]), "R12 burst decode", 32'(xfer_burst), 32'(bw[k]));
    end

    // soft reset while running
    ack_mode = 0;
    wr_reg(4'h0, C_EN);
    rd_chk(4'h0, C_CYC | C_ON, C_CYC | C_ON, "R13 pending while stalled");
    wr_reg(4'h0, C_EN | C_SRST);
    idle(3);
    rd_chk(4'h0, C_CYC | C_ON | C_SRST | C_AL, C_SRST, "R11 quiet under soft reset");
    chk(xfer_req == 0, "R11 no request", 32'(xfer_req), 0);
    wr_reg(4'h0, 0);

    // odd count floors at zero
    ack_mode = 3;
    wr_reg(4'h4, 32'h0000_5000);
    wr_reg(4'h8, 32'd6);
    wr_reg(4'h0, C_EN | C_CEN);
    idle(20);
    rd_chk(4'h8, 32'hFFFF_FFFF, 0, "R4 count floored");
    rd_chk(4'h4, 32'hFFFF_FFFF, 32'h0000_5008, "R4 two words moved");
    rd_chk(4'h0, C_TC | C_EN, C_TC, "R5 R7 terminal count after floor");
    idle(2);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule